// File: doc/BRIEF.md
# Memory Barrier and Low-Power Entry Controller

This controller sits beside the issue stage and carries out a barrier instruction that has a 5-bit immediate. The two low immediate bits choose which sides must drain before execution goes on: instruction fetch, data access, or both. Two outstanding-access counters track this. Each counter rises when a request is accepted and falls when a response returns. Issue stays stalled until every counter that has been selected reads zero. After that, a fixed settling latency runs. It is 2 cycles for a plain interconnect and 8 cycles for a coherent one. The instruction then completes and the program counter moves forward by 4.

The two upper immediate bits request a low-power state: sleep, hibernate or suspend. A low-power request drains both sides, whatever the low bits say. When it completes, the matching output is held and the pipeline stays halted until any bit of the wakeup input goes high. When memory management is enabled, a request in user mode with immediate bit 4 set is refused. The controller instead raises a privileged-instruction exception and writes the cause code. An immediate whose low bits are `10` also makes the controller flush the branch target cache and the prefetch buffer.

Top module: `mbar_sleep_ctrl`

## Requirements
- R1: When immediate bit 0 is 0, completion waits until the instruction-side outstanding count is zero. Each cycle with a nonzero count at a clock edge adds one cycle of latency.
- R2: When immediate bit 1 is 0, completion waits until the data-side outstanding count is zero, in the same way. When a side's bit is 1, that side's count is not waited on.
- R3: When immediate bits [1:0] equal `10`, `flush` is high for exactly the one cycle in which `done` is high.
- R4: Take the cycle in which `issue` is high as cycle 0. `done` is then a single-cycle pulse in cycle LAT+N. LAT is 2 when `COHERENT`=0 and 8 when it is 1. N is the number of drain cycles.
- R5: In the cycle `done` is high, `pc_o` equals the `pc_i` that was sampled at issue, plus 4.
- R6: Immediate bits [4:3] select the low-power state: `10` gives sleep, `01` gives hibernate, `11` gives suspend, and `00` gives none. Any selection drains both sides. From the cycle after `done`, exactly one matching output is high and `stall` is high.
- R7: While in a low-power state, a wakeup with any bit set drops the low-power output and `stall` together, one cycle later.
- R8: With `USE_MMU`=1, `user_mode`=1 and immediate bit 4 set, `priv_exc` is high in cycle 1 and `exc_cause` becomes 7. No `done`, `flush` or low-power output follows, and `pc_o` is unchanged. Hibernate (bits [4:3]=`01`) is not refused in user mode.
- R9: A barrier that completes without an exception leaves `exc_cause` unchanged.
- R10: An `issue` that arrives while the controller is busy, including the low-power state, is ignored. No `done` is produced and `pc_o` does not change.
- R11: After reset, `stall`, `done`, `flush`, `priv_exc` and the low-power outputs are 0, and `pc_o` and `exc_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Barrier instruction is issued this cycle |
| imm | input | 5 | Barrier immediate |
| pc_i | input | PC_W | Program counter of the barrier |
| user_mode | input | 1 | Processor is in user mode |
| i_acc | input | 1 | Instruction-side request accepted |
| i_rsp | input | 1 | Instruction-side response returned |
| d_acc | input | 1 | Data-side request accepted |
| d_rsp | input | 1 | Data-side response returned |
| wakeup | input | WAKE_W | Wakeup lines; any set bit resumes |
| stall | output | 1 | Hold issue |
| done | output | 1 | Barrier completes this cycle |
| flush | output | 1 | Clear branch target cache and prefetch buffer |
| pc_o | output | PC_W | Advanced program counter |
| sleep_o | output | 1 | In sleep state |
| hibernate_o | output | 1 | In hibernate state |
| suspend_o | output | 1 | In suspend state |
| priv_exc | output | 1 | Privileged-instruction exception |
| exc_cause | output | 5 | Exception cause field |

## Verification
The immediate is tried with each combination of its two wait bits, and different numbers of instruction and data accesses are left outstanding in each case. The completion cycle therefore shows which side's drain was waited on. Each low-power code is also tried after uneven drains, which shows that a low-power request drains both sides no matter what the low bits say. A low-power code in user mode separates the refused codes from the allowed hibernate code. An issue sent during the halt, followed by a wakeup on a single line, shows that busy issue is ignored and that the controller resumes on any wakeup bit.

// File: rtl/mbar_sleep_ctrl.sv
module mbar_sleep_ctrl #(
  parameter int PC_W     = 32,
  parameter int CNT_W    = 4,
  parameter int WAKE_W   = 2,
  parameter bit USE_MMU  = 1'b1,
  parameter bit COHERENT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [4:0]        imm,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              user_mode,
  input  logic              i_acc,
  input  logic              i_rsp,
  input  logic              d_acc,
  input  logic              d_rsp,
  input  logic [WAKE_W-1:0] wakeup,
  output logic              stall,
  output logic              done,
  output logic              flush,
  output logic [PC_W-1:0]   pc_o,
  output logic              sleep_o,
  output logic              hibernate_o,
  output logic              suspend_o,
  output logic              priv_exc,
  output logic [4:0]        exc_cause
);
  localparam int LAT      = COHERENT ? 8 : 2;
  localparam int TAIL_INI = (LAT > 2) ? LAT - 3 : 0;
  localparam logic [4:0] EC_PRIV = 5'd7;

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_TAIL, S_FIN, S_LP, S_EXC} st_t;
  st_t state;

  logic [CNT_W-1:0] i_cnt, d_cnt;
  logic [3:0]       tcnt;
  logic [PC_W-1:0]  pc_hold;
  logic             wait_i, wait_d, do_flush;
  logic [1:0]       lpm;

  wire priv_hit = USE_MMU && imm[4] && user_mode;
  wire drained  = (!wait_i || i_cnt == '0) && (!wait_d || d_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_cnt <= '0;
      d_cnt <= '0;
    end else begin
      if (i_acc && !i_rsp) i_cnt <= i_cnt + CNT_W'(1);
      else if (i_rsp && !i_acc) i_cnt <= i_cnt - CNT_W'(1);
      if (d_acc && !d_rsp) d_cnt <= d_cnt + CNT_W'(1);
      else if (d_rsp && !d_acc) d_cnt <= d_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      pc_hold   <= '0;
      pc_o      <= '0;
      wait_i    <= 1'b0;
      wait_d    <= 1'b0;
      do_flush  <= 1'b0;
      lpm       <= 2'b00;
      exc_cause <= '0;
    end else begin
      case (state)
        S_IDLE: if (issue) begin
          pc_hold <= pc_i;
          if (priv_hit) begin
            exc_cause <= EC_PRIV;
            state     <= S_EXC;
          end else begin
            wait_i   <= !imm[0] || (imm[4:3] != 2'b00);
            wait_d   <= !imm[1] || (imm[4:3] != 2'b00);
            do_flush <= (imm[1:0] == 2'b10);
            lpm      <= imm[4:3];
            state    <= S_DRAIN;
          end
        end
        S_DRAIN: if (drained) begin
          if (LAT == 2) begin
            pc_o  <= pc_hold + PC_W'(4);
            state <= S_FIN;
          end else begin
            tcnt  <= 4'(TAIL_INI);
            state <= S_TAIL;
          end
        end
        S_TAIL: if (tcnt == '0) begin
          pc_o  <= pc_hold + PC_W'(4);
          state <= S_FIN;
        end else begin
          tcnt <= tcnt - 4'd1;
        end
        S_FIN:   state <= (lpm != 2'b00) ? S_LP : S_IDLE;
        S_LP:    if (|wakeup) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done        = (state == S_FIN);
  assign flush       = done && do_flush;
  assign priv_exc    = (state == S_EXC);
  assign sleep_o     = (state == S_LP) && (lpm == 2'b10);
  assign hibernate_o = (state == S_LP) && (lpm == 2'b01);
  assign suspend_o   = (state == S_LP) && (lpm == 2'b11);
  assign stall       = (state == S_DRAIN) || (state == S_TAIL) || (state == S_LP) ||
                       (done && lpm != 2'b00);

  wire any_lp = sleep_o || hibernate_o || suspend_o;

  a_r6_one_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_o, hibernate_o, suspend_o}));
  a_r6_lp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_lp) |-> $past(done));
  a_r3_flush_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> done);
  a_r8_exc_alone: assert property (@(posedge clk) disable iff (!rst_n)
    priv_exc |-> (!done && !flush && !any_lp && exc_cause == EC_PRIV));
  a_r7_wake_release: assert property (@(posedge clk) disable iff (!rst_n)
    (any_lp && |wakeup) |=> (!any_lp && !stall));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_drain_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!wait_i || i_cnt == '0 || state != S_DRAIN));
endmodule

// File: tb/sim_mbar_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_mbar_sleep_ctrl;
  localparam int LAT = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 1'b0, user_mode = 1'b0;
  logic [4:0] imm = '0;
  logic [31:0] pc_i = '0;
  logic i_acc = 1'b0, i_rsp = 1'b0, d_acc = 1'b0, d_rsp = 1'b0;
  logic [1:0] wakeup = '0;
  logic stall, done, flush, sleep_o, hibernate_o, suspend_o, priv_exc;
  logic [31:0] pc_o;
  logic [4:0] exc_cause;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbar_sleep_ctrl #(.PC_W(32), .CNT_W(4), .WAKE_W(2), .USE_MMU(1'b1), .COHERENT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .imm(imm), .pc_i(pc_i), .user_mode(user_mode),
    .i_acc(i_acc), .i_rsp(i_rsp), .d_acc(d_acc), .d_rsp(d_rsp), .wakeup(wakeup),
    .stall(stall), .done(done), .flush(flush), .pc_o(pc_o), .sleep_o(sleep_o),
    .hibernate_o(hibernate_o), .suspend_o(suspend_o), .priv_exc(priv_exc), .exc_cause(exc_cause));

  typedef struct packed {
    logic [4:0] imm; logic usr; logic [2:0] ni; logic [2:0] nd;
    logic [3:0] n; logic fl; logic [1:0] lp; logic exc;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{5'd0,  1'b0, 3'd2, 3'd3, 4'd3, 1'b0, 2'b00, 1'b0},
    '{5'd1,  1'b0, 3'd3, 3'd1, 4'd1, 1'b0, 2'b00, 1'b0},
    '{5'd2,  1'b0, 3'd1, 3'd3, 4'd1, 1'b1, 2'b00, 1'b0},
    '{5'd3,  1'b0, 3'd2, 3'd2, 4'd0, 1'b0, 2'b00, 1'b0},
    '{5'd19, 1'b0, 3'd2, 3'd1, 4'd2, 1'b0, 2'b10, 1'b0},
    '{5'd11, 1'b1, 3'd1, 3'd0, 4'd1, 1'b0, 2'b01, 1'b0},
    '{5'd24, 1'b0, 3'd0, 3'd0, 4'd0, 1'b0, 2'b11, 1'b0},
    '{5'd16, 1'b1, 3'd0, 3'd0, 4'd0, 1'b0, 2'b00, 1'b1},
    '{5'd26, 1'b1, 3'd0, 3'd0, 4'd0, 1'b0, 2'b00, 1'b1},
    '{5'd2,  1'b0, 3'd0, 3'd0, 4'd0, 1'b1, 2'b00, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev_pc;
    logic [4:0]  prev_cause;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!stall && !done && !flush && !priv_exc, "R11 control outputs", {stall, done, flush, priv_exc}, 0);
    chk(!sleep_o && !hibernate_o && !suspend_o, "R11 low-power outputs", {sleep_o, hibernate_o, suspend_o}, 0);
    chk(pc_o == 0 && exc_cause == 0, "R11 pc and cause", {pc_o, 3'b0, exc_cause}, 0);
    prev_pc = 0; prev_cause = 0;

    for (int v = 0; v < 10; v++) begin
      vec_t t;
      int dcyc, ndone;
      logic [31:0] exp_pc;
      t = TBL[v];
      for (int k = 0; k < 4; k++) begin
        i_acc = (k < int'(t.ni));
        d_acc = (k < int'(t.nd));
        @(negedge clk);
      end
      i_acc = 0; d_acc = 0;
      imm = t.imm; user_mode = t.usr; pc_i = 32'h100 * (v + 1); issue = 1;
      exp_pc = pc_i + 4;
      @(negedge clk);
      issue = 0;
      dcyc = -1; ndone = 0;
      for (int cyc = 1; cyc <= 14; cyc++) begin
        if (done) begin
          ndone++;
          if (dcyc < 0) begin
            dcyc = cyc;
            chk(flush == t.fl, "R3 flush with done", flush, t.fl);
            chk(pc_o == exp_pc, "R5 pc advance", pc_o, exp_pc);
          end
        end
        if (t.exc && cyc == 1) begin
          chk(priv_exc, "R8 exception raised", priv_exc, 1);
          chk(exc_cause == 5'd7, "R8 cause written", exc_cause, 7);
        end
        if (t.exc) chk(!flush && !sleep_o && !hibernate_o && !suspend_o, "R8 no side effects",
                       {flush, sleep_o, hibernate_o, suspend_o}, 0);
        if (t.lp != 0 && dcyc > 0 && cyc == dcyc + 1) begin
          chk({sleep_o, hibernate_o, suspend_o} ==
              {t.lp == 2'b10, t.lp == 2'b01, t.lp == 2'b11}, "R6 low-power output",
              {sleep_o, hibernate_o, suspend_o}, t.lp);
          chk(stall, "R6 halted", stall, 1);
        end
        i_rsp = (cyc <= int'(t.ni));
        d_rsp = (cyc <= int'(t.nd));
        @(negedge clk);
      end
      i_rsp = 0; d_rsp = 0;
      if (t.exc) begin
        chk(ndone == 0, "R8 no completion", ndone, 0);
        chk(pc_o == prev_pc, "R8 pc unchanged", pc_o, prev_pc);
        prev_cause = 5'd7;
      end else begin
        chk(ndone == 1, "R4 single done pulse", ndone, 1);
        chk(dcyc == LAT + int'(t.n), "R4 latency (R1 R2 drain)", dcyc, LAT + int'(t.n));
        chk(exc_cause == prev_cause, "R9 cause kept", exc_cause, prev_cause);
        prev_pc = exp_pc;
      end
      if (t.lp != 0) begin
        // R10: issue during low-power state is ignored
        imm = 5'd0; user_mode = 0; pc_i = 32'hDEAD0000; issue = 1;
        @(negedge clk);
        issue = 0;
        chk(stall, "R10 still halted", stall, 1);
        wakeup = 2'b10;
        @(negedge clk);
        wakeup = 0;
        chk(!stall && !sleep_o && !hibernate_o && !suspend_o, "R7 wake release",
            {stall, sleep_o, hibernate_o, suspend_o}, 0);
        ndone = 0;
        repeat (4) begin
          if (done) ndone++;
          @(negedge clk);
        end
        chk(ndone == 0 && pc_o == prev_pc, "R10 busy issue ignored", pc_o, prev_pc);
      end
      repeat (2) @(negedge clk);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule